// File: doc/BRIEF.md
# CPU Clock Stop Gate

This block turns a group of CPU clock outputs off and back on in response to an active-low stop request. The request is sampled only on the rising edge of the free-running PCI clock. The PCI clock is derived from the same source as the CPU clock, and its rising edges line up with CPU rising edges. The block does not generate or touch the PCI and SDRAM clocks, so they keep running while the CPU clocks are parked.

A single enable register, clocked on the falling edge of the CPU source clock, feeds one AND gate per output. The enable can therefore change only while the source clock is low. Each output is either a copy of the source clock with full high and low phases or a constant low level. It never produces a shortened pulse.

After reset the enable is set, so the outputs run until a stop request is sampled. Both stop latency and restart latency are under two CPU periods.

Top module: `cpu_clk_stop_ctrl`

## Requirements
- R1: While rst_ni is low, every cpu_clk_o bit follows cpu_clk_i whatever stop_ni does. After reset is released, the outputs keep running until a low stop_ni is sampled.
- R2: stop_ni is sampled only on rising edges of pci_clk_i. A low or high level that comes and goes between two such edges has no effect on cpu_clk_o.
- R3: While the most recently sampled stop_ni is 0, every cpu_clk_o bit stays at 0 for every phase of cpu_clk_i.
- R4: Take a PCI rising edge at which stop_ni is sampled as 0. The CPU high phase that starts at that edge is delivered in full. The next CPU rising edge, one period later, produces no output pulse. Stop latency is therefore under two CPU periods.
- R5: Take a PCI rising edge at which stop_ni is sampled as 1 after a stop. The first output pulse starts at the CPU rising edge one period later, so restart latency is under two CPU periods.
- R6: Every high phase of a cpu_clk_o bit lasts exactly as long as the high phase of cpu_clk_i. No output is high while cpu_clk_i is low.
- R7: All cpu_clk_o bits are equal at all times, so they stop and start on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | CPU source clock |
| pci_clk_i | input | 1 | Free-running PCI clock, rising edges aligned with cpu_clk_i rising edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_ni | input | 1 | Stop request, active low (0 = stop, 1 = run) |
| cpu_clk_o | output | NUM_CLKS | Gated CPU clock outputs |

## Verification
A stop or run level sampled at PCI edge P is visible on the outputs no earlier than the CPU high phase that starts at P+1 period. The high phase that starts at P itself still reflects the previous state. Each directed step therefore drives stop_ni in the middle of a PCI low phase and waits for the next PCI rising edge. It then samples the outputs 5 ns after that edge to see the old state, and 25 ns and 45 ns after it to see the new state. An edge monitor on every output measures the width of each high and low phase against the 10 ns source half-period.

// File: rtl/cpu_clk_stop_pkg.sv
`timescale 1ns/1ps
package cpu_clk_stop_pkg;
  localparam int unsigned DefNumClks = 4;
  // sampled request encoding: 1 = run, 0 = park low
  localparam logic ReqRun  = 1'b1;
  localparam logic ReqPark = 1'b0;
endpackage

// File: rtl/stop_req_sampler.sv
`timescale 1ns/1ps
module stop_req_sampler
  import cpu_clk_stop_pkg::*;
(
  input  logic pci_clk_i,
  input  logic rst_ni,
  input  logic stop_ni,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge pci_clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= ReqRun;
    else         run_q <= stop_ni ? ReqRun : ReqPark;
  end

  assign run_o = run_q;
endmodule

// File: rtl/gate_enable_reg.sv
`timescale 1ns/1ps
module gate_enable_reg
  import cpu_clk_stop_pkg::*;
(
  input  logic cpu_clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic en_o
);
  logic en_q;

  // falling-edge update keeps enable changes inside the low phase
  always_ff @(negedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= ReqRun;
    else         en_q <= run_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/clk_and_gate.sv
`timescale 1ns/1ps
module clk_and_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  assign clk_o = clk_i & en_i;
endmodule

// File: rtl/cpu_clk_stop_ctrl.sv
`timescale 1ns/1ps
module cpu_clk_stop_ctrl
  import cpu_clk_stop_pkg::*;
#(
  parameter int unsigned NUM_CLKS = DefNumClks
) (
  input  logic                cpu_clk_i,
  input  logic                pci_clk_i,
  input  logic                rst_ni,
  input  logic                stop_ni,
  output logic [NUM_CLKS-1:0] cpu_clk_o
);
  logic run_q;
  logic en_q;

  stop_req_sampler u_sampler (
    .pci_clk_i (pci_clk_i),
    .rst_ni    (rst_ni),
    .stop_ni   (stop_ni),
    .run_o     (run_q)
  );

  gate_enable_reg u_enable (
    .cpu_clk_i (cpu_clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .en_o      (en_q)
  );

  for (genvar g = 0; g < NUM_CLKS; g++) begin : g_gate
    clk_and_gate u_gate (
      .clk_i (cpu_clk_i),
      .en_i  (en_q),
      .clk_o (cpu_clk_o[g])
    );
  end
endmodule

// File: rtl/cpu_clk_stop_chk.sv
`timescale 1ns/1ps
module cpu_clk_stop_chk #(
  parameter int unsigned NUM_CLKS = 4
) (
  input logic                cpu_clk_i,
  input logic                rst_ni,
  input logic                run_q,
  input logic [NUM_CLKS-1:0] cpu_clk_o
);
  // R6: sampled just before a rising edge, the source is low, so outputs must be low
  no_high_in_low_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    cpu_clk_o == '0);

  // R7
  outputs_aligned_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_clk_o == '0) || (cpu_clk_o == '1));

  // R4
  stop_parks_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    $fell(run_q) |=> cpu_clk_o == '0);

  // R5
  restart_pulse_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    $rose(run_q) |=> cpu_clk_o == '1);

  // R3
  held_low_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (!run_q && $past(!run_q)) |-> cpu_clk_o == '0);
endmodule

bind cpu_clk_stop_ctrl cpu_clk_stop_chk #(.NUM_CLKS(NUM_CLKS)) u_chk (
  .cpu_clk_i (cpu_clk_i),
  .rst_ni    (rst_ni),
  .run_q     (run_q),
  .cpu_clk_o (cpu_clk_o)
);

// File: tb/cpu_clk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module cpu_clk_stop_ctrl_bench;
  localparam int unsigned N = 4;

  logic         cpu_clk = 1'b0;
  logic         pci_clk = 1'b0;
  logic         rst_n   = 1'b0;
  logic         stop_n  = 1'b1;
  logic [N-1:0] clk_out;

  int checks = 0;
  int errors = 0;
  int runts  = 0;
  int pulses = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  cpu_clk_stop_ctrl #(.NUM_CLKS(N)) u_cpu_clk_stop_ctrl (
    .cpu_clk_i (cpu_clk),
    .pci_clk_i (pci_clk),
    .rst_ni    (rst_n),
    .stop_ni   (stop_n),
    .cpu_clk_o (clk_out)
  );

  // 50 MHz CPU clock; PCI at one third, rising with CPU rising edges
  always #10 cpu_clk = ~cpu_clk;
  initial begin
    #10 pci_clk = 1'b1;
    forever begin
      #30 pci_clk = 1'b0;
      #30 pci_clk = 1'b1;
    end
  end

  // R6: phase-width monitor per output
  for (genvar g = 0; g < N; g++) begin : g_mon
    realtime t_rise = 0.0;
    realtime t_fall = 0.0;
    always @(posedge clk_out[g]) begin
      if (mon_on && t_fall > 0.0 && ($realtime - t_fall) < 10.0) runts++;
      t_rise = $realtime;
    end
    always @(negedge clk_out[g]) begin
      if (mon_on) begin
        pulses++;
        if (($realtime - t_rise) != 10.0) runts++;
      end
      t_fall = $realtime;
    end
  end

  task automatic check_out(input logic exp, input string req);
    logic [N-1:0] want;
    want = exp ? '1 : '0;
    checks++;
    if (clk_out !== want) begin
      errors++;
      $display("FAIL %s at %0t: cpu_clk_o=%b expected %b", req, $time, clk_out, want);
    end
  endtask

  // drive mid PCI low phase, return at the next PCI rising edge
  task automatic drive_stop(input logic v);
    @(negedge pci_clk);
    #3 stop_n = v;
    @(posedge pci_clk);
  endtask

  // {stop_n, expected 5ns after edge, expected 25/45ns after edge}
  localparam logic [2:0] VEC [7] = '{3'b111, 3'b010, 3'b000, 3'b101,
                                     3'b010, 3'b101, 3'b111};

  initial begin
    // R1: reset overrides a low stop request
    stop_n = 1'b0;
    repeat (2) @(posedge pci_clk);
    #5  check_out(1'b1, "R1 reset high phase");
    #10 check_out(1'b0, "R1 reset low phase");
    @(negedge pci_clk);
    #3 stop_n = 1'b1;
    rst_n = 1'b1;
    @(posedge pci_clk);
    #25 check_out(1'b1, "R1 running after reset");
    mon_on = 1'b1;

    // R3 R4 R5: table walk
    for (int i = 0; i < 7; i++) begin
      drive_stop(VEC[i][2]);
      #5  check_out(VEC[i][1], VEC[i][2] ? "R5 old state kept at edge" : "R4 pulse at edge completes");
      #20 check_out(VEC[i][0], VEC[i][2] ? "R5 first pulse one period later" : "R4 parked one period later");
      #20 check_out(VEC[i][0], VEC[i][2] ? "R5 still running" : "R3 still parked");
    end

    // R2: short low between PCI edges ignored while running
    @(negedge pci_clk);
    #3 stop_n = 1'b0;
    #20 stop_n = 1'b1;
    @(posedge pci_clk);
    #25 check_out(1'b1, "R2 short low ignored");
    #20 check_out(1'b1, "R2 short low ignored");

    // R2/R3: short high between edges ignored while parked
    drive_stop(1'b0);
    #25 check_out(1'b0, "R3 parked");
    @(negedge pci_clk);
    #3 stop_n = 1'b1;
    #20 stop_n = 1'b0;
    @(posedge pci_clk);
    #25 check_out(1'b0, "R2 short high ignored");
    #20 check_out(1'b0, "R2 short high ignored");

    // R3: long park
    repeat (20) @(posedge cpu_clk);
    #5 check_out(1'b0, "R3 long park");
    drive_stop(1'b1);
    #25 check_out(1'b1, "R5 restart after long park");

    // R1: reset while parked restarts the clocks at once
    drive_stop(1'b0);
    #25 check_out(1'b0, "R3 parked before reset");
    mon_on = 1'b0;
    @(negedge cpu_clk);
    #3 rst_n = 1'b0;
    @(posedge cpu_clk);
    #5 check_out(1'b1, "R1 reset forces run");
    @(negedge pci_clk);
    #3 rst_n = 1'b1;
    @(posedge pci_clk);
    #25 check_out(1'b0, "R1 stop seen after reset");
    drive_stop(1'b1);
    #25 check_out(1'b1, "R1 run after reset");

    // R6/R7 monitor verdicts
    checks++;
    if (runts != 0) begin
      errors++;
      $display("FAIL R6 runt phases: actual %0d expected 0", runts);
    end
    checks++;
    if (pulses == 0 || (pulses % N) != 0) begin
      errors++;
      $display("FAIL R7 pulse count per output uneven: actual %0d expected multiple of %0d", pulses, N);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule